// File: doc/BRIEF.md
# Upstream Port Speed Negotiation Controller

This block governs how the upstream port of a hub reacts when the host holds the bus at SE0 for a long time. If the port is running at full speed, a long SE0 is a bus reset. The block then drives a chirp K upstream and listens for the host's alternating K/J chirps. When it hears enough of them it switches the port to high-speed operation. If it hears none within a timeout, it stays at full speed.

If the port is already running at high speed, a long SE0 can mean either a suspend or a reset. The block first reverts to full speed by turning the full-speed pull-up back on. After a short check window it samples the line again:
- If SE0 is still present, the event is a reset, and the block begins chirping.
- Otherwise the event is a suspend, and the block stays in the full-speed idle state.

While the port is suspended, a much shorter SE0 run is enough to start the handshake. Every interval is a parameter counted in clock cycles, so the real-time windows are set by the integrator for the clock in use.

The line state input is already sampled, with this encoding: 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1.

Top module: `upstream_speed_handshake`

## Requirements
- R1: After reset the block is at full speed, with `fs_pullup`=1, `hs_term`=0, `hs_mode`=0 and `chirp_k`=0.
- R2: In the full-speed idle state with `suspended`=0, `chirp_k` rises after `T_FS_SE0` consecutive sampled SE0 cycles. Any non-SE0 sample restarts the count.
- R3: In the full-speed idle state with `suspended`=1, `T_SUSP_SE0` consecutive SE0 cycles are enough to start chirping.
- R4: `chirp_k` stays high for exactly `T_CHIRP` cycles, and `fs_pullup` remains 1 during the chirp.
- R5: After the chirp, a host K (2'b10) or J (2'b01) counts only once it has been held for `T_FILT` consecutive cycles. Shorter runs are ignored. A J counts toward a pair only after a counted K.
- R6: On the cycle after the `MIN_PAIRS`-th counted K-then-J pair, `hs_mode`=1, `hs_term`=1 and `fs_pullup`=0.
- R7: If fewer than `MIN_PAIRS` pairs are counted within `T_HOST_WAIT` cycles after the chirp ends, the block returns to full-speed idle without enabling high speed.
- R8: In high-speed mode, `T_HS_REVERT` consecutive SE0 cycles drop `hs_mode` and `hs_term` and raise `fs_pullup`. A shorter SE0 run has no effect.
- R9: `T_REV_CHECK` cycles after reverting, the block samples the line:
  - SE0 means reset, and `chirp_k` rises.
  - Any other value means suspend, and the block stays in full-speed idle with no chirp.
- R10: `fs_pullup` and `hs_term` are never both high, and `chirp_k` is never high while `hs_mode` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | Sampled upstream line: 00 SE0, 01 J, 10 K, 11 SE1 |
| suspended | input | 1 | Port is currently suspended |
| chirp_k | output | 1 | Request to drive chirp K upstream |
| fs_pullup | output | 1 | Enable the full-speed pull-up |
| hs_term | output | 1 | Enable high-speed termination |
| hs_mode | output | 1 | Port is operating at high speed |

## Verification
The bench builds the block with very short windows:
- suspended wait of 4 cycles and full-speed wait of 10;
- revert time of 20 cycles and revert check window of 5;
- chirp length of 8 cycles and host timeout of 60;
- chirp filter of 3 cycles and 3 required pairs.

With these values, a single run fits several complete negotiations. It covers a reset from full speed, a suspend and a reset both entered from high speed, the shortened wait while suspended, and a timeout when the host stays silent. The short filter also makes it possible to drive sub-threshold glitches and chirps that start on J.

// File: rtl/upstream_speed_handshake.sv
module upstream_speed_handshake #(
  parameter int T_SUSP_SE0  = 75,
  parameter int T_FS_SE0    = 3000,
  parameter int T_HS_REVERT = 91875,
  parameter int T_REV_CHECK = 3000,
  parameter int T_CHIRP     = 45000,
  parameter int T_HOST_WAIT = 60000,
  parameter int T_FILT      = 75,
  parameter int MIN_PAIRS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  input  logic       suspended,
  output logic       chirp_k,
  output logic       fs_pullup,
  output logic       hs_term,
  output logic       hs_mode
);
  localparam int M1 = (T_SUSP_SE0 > T_FS_SE0) ? T_SUSP_SE0 : T_FS_SE0;
  localparam int M2 = (T_HS_REVERT > T_REV_CHECK) ? T_HS_REVERT : T_REV_CHECK;
  localparam int M3 = (T_CHIRP > T_HOST_WAIT) ? T_CHIRP : T_HOST_WAIT;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M4 > M3) ? M4 : M3;
  localparam int CW = $clog2(TMAX + 1);
  localparam int RW = $clog2(T_FILT + 1);
  localparam int PW = $clog2(MIN_PAIRS + 1);
  localparam logic [1:0] LS_SE0 = 2'b00, LS_J = 2'b01, LS_K = 2'b10;

  typedef enum logic [2:0] {S_FS, S_CHIRP, S_WAIT, S_HS, S_REVERT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    prev_ls;
  logic [RW-1:0] run;
  logic [PW-1:0] pairs;
  logic          seen_k;

  wire           is_se0  = line_state == LS_SE0;
  wire           is_chip = (line_state == LS_J) || (line_state == LS_K);
  wire [CW-1:0]  cnt_nx  = cnt + 1'b1;
  wire [CW-1:0]  fs_thr  = suspended ? CW'(T_SUSP_SE0) : CW'(T_FS_SE0);
  wire           same    = line_state == prev_ls;
  wire           evt     = same && is_chip && (run == RW'(T_FILT - 1));
  wire           j_pair  = evt && (line_state == LS_J) && seen_k;
  wire           got_hs  = j_pair && (pairs == PW'(MIN_PAIRS - 1));

  assign chirp_k   = st == S_CHIRP;
  assign hs_mode   = st == S_HS;
  assign hs_term   = hs_mode;
  assign fs_pullup = !hs_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FS;
      cnt     <= '0;
      prev_ls <= LS_SE0;
      run     <= '0;
      pairs   <= '0;
      seen_k  <= 1'b0;
    end else begin
      case (st)
        S_FS: begin
          if (!is_se0) cnt <= '0;
          else if (cnt_nx >= fs_thr) begin
            st  <= S_CHIRP;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        S_CHIRP: begin
          if (cnt_nx >= CW'(T_CHIRP)) begin
            st      <= S_WAIT;
            cnt     <= '0;
            prev_ls <= LS_SE0;
            run     <= '0;
            pairs   <= '0;
            seen_k  <= 1'b0;
          end else cnt <= cnt_nx;
        end
        S_WAIT: begin
          prev_ls <= line_state;
          if (!same) run <= RW'(1);
          else if (run != RW'(T_FILT)) run <= run + 1'b1;
          if (evt && line_state == LS_K) seen_k <= 1'b1;
          if (j_pair) begin
            seen_k <= 1'b0;
            pairs  <= pairs + 1'b1;
          end
          if (got_hs) begin
            st  <= S_HS;
            cnt <= '0;
          end else if (cnt_nx >= CW'(T_HOST_WAIT)) begin
            st  <= S_FS;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        S_HS: begin
          if (!is_se0) cnt <= '0;
          else if (cnt_nx >= CW'(T_HS_REVERT)) begin
            st  <= S_REVERT;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        S_REVERT: begin
          if (cnt_nx >= CW'(T_REV_CHECK)) begin
            st  <= is_se0 ? S_CHIRP : S_FS;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        default: begin
          st  <= S_FS;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/upstream_speed_handshake_chk.sv
module upstream_speed_handshake_chk #(
  parameter int T_CHIRP = 45000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_state,
  input logic       chirp_k,
  input logic       fs_pullup,
  input logic       hs_term,
  input logic       hs_mode
);
  logic [31:0] k_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) k_run <= '0;
    else k_run <= chirp_k ? k_run + 1 : '0;

  a_r4_chirp_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chirp_k) |-> k_run == 32'(T_CHIRP));

  a_r2_chirp_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_k) |-> $past(line_state) == 2'b00);

  a_r5_hs_after_held_j: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> ($past(line_state) == 2'b01) && ($past(line_state, 2) == 2'b01));

  a_r8_hs_exit_on_se0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> $past(line_state) == 2'b00);

  a_r10_no_pullup_with_term: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_pullup && hs_term));

  a_r10_no_chirp_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode |-> !chirp_k);
endmodule

bind upstream_speed_handshake upstream_speed_handshake_chk #(.T_CHIRP(T_CHIRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_state(line_state), .chirp_k(chirp_k),
  .fs_pullup(fs_pullup), .hs_term(hs_term), .hs_mode(hs_mode)
);

// File: tb/upstream_speed_handshake_bench.sv
module upstream_speed_handshake_bench;
  localparam int PERIOD = 10;
  localparam int TS = 4, TF = 10, TR = 20, TK = 5, TC = 8, TH = 60, TFL = 3, NP = 3;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line = J;
  logic susp = 1'b0;
  logic chirp_k, fs_pullup, hs_term, hs_mode;

  always #(PERIOD/2) clk = ~clk;

  upstream_speed_handshake #(
    .T_SUSP_SE0(TS), .T_FS_SE0(TF), .T_HS_REVERT(TR), .T_REV_CHECK(TK),
    .T_CHIRP(TC), .T_HOST_WAIT(TH), .T_FILT(TFL), .MIN_PAIRS(NP)
  ) u_upstream_speed_handshake (
    .clk(clk), .rst_n(rst_n), .line_state(line), .suspended(susp),
    .chirp_k(chirp_k), .fs_pullup(fs_pullup), .hs_term(hs_term), .hs_mode(hs_mode)
  );

  int errors = 0, checks = 0;
  // model: 0 idle fs, 1 chirp, 2 waiting for host, 3 high speed, 4 reverted
  int mode = 0, t = 0, run = 0, pairs = 0, since_rst = 0;
  logic [1:0] prev = SE0;
  bit seenk = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; t = 0; since_rst = 0;
    end else begin
      since_rst++;
      case (mode)
        0: if (line == SE0) begin
             t++;
             if (t >= (susp ? TS : TF)) begin mode = 1; t = 0; end
           end else t = 0;
        1: begin
             t++;
             if (t >= TC) begin mode = 2; t = 0; prev = SE0; run = 0; pairs = 0; seenk = 0; end
           end
        2: begin
             bit ev;
             t++;
             run = (line == prev) ? run + 1 : 1;
             prev = line;
             ev = (run == TFL) && (line == J || line == K);
             if (ev && line == K) seenk = 1;
             else if (ev && line == J && seenk) begin seenk = 0; pairs++; end
             if (pairs == NP) begin mode = 3; t = 0; pairs = 0; end
             else if (t >= TH) begin mode = 0; t = 0; end
           end
        3: if (line == SE0) begin
             t++;
             if (t >= TR) begin mode = 4; t = 0; end
           end else t = 0;
        default: begin
             t++;
             if (t >= TK) begin mode = (line == SE0) ? 1 : 0; t = 0; end
           end
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tag;
    if (since_rst == 0) tag = "R1";
    else case (mode)
      0: tag = susp ? "R3" : "R2";
      1: tag = "R4";
      2: tag = "R5 R7";
      3: tag = "R6 R8";
      default: tag = "R9";
    endcase
    chk(tag, chirp_k, mode == 1, "chirp_k");
    chk(tag, hs_mode, mode == 3, "hs_mode");
    chk(tag, hs_term, mode == 3, "hs_term");
    chk(tag, fs_pullup, mode != 3, "fs_pullup");
    chk("R10", fs_pullup && hs_term, 1'b0, "pullup_and_term");
    chk("R10", chirp_k && hs_mode, 1'b0, "chirp_in_hs");
  endtask

  task automatic step(input logic [1:0] ls, input logic s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      line = ls;
      susp = s;
    end
  endtask

  task automatic host_pairs(input logic s);
    for (int i = 0; i < NP; i++) begin
      step(K, s, 4);
      step(J, s, 4);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(J, 0, 3);
    step(SE0, 0, 6);  step(J, 0, 1);  step(SE0, 0, 20);
    step(K, 0, 2);    step(J, 0, 2);
    host_pairs(0);
    step(SE0, 0, 15); step(J, 0, 2);  step(SE0, 0, 25);
    step(SE0, 0, 80); step(J, 0, 5);
    step(SE0, 0, 20); host_pairs(0);
    step(SE0, 0, 22); step(J, 0, 10);
    step(SE0, 1, 14); step(J, 1, 4);  host_pairs(1);
    step(J, 0, 5);
    step(SE0, 0, 10); step(K, 0, 3);  step(SE0, 0, 70);
    step(J, 0, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule